// File: doc/BRIEF.md
# MD5/SHA1 Message Padding Word Generator

This block produces the closing words of a message for an MD5 or SHA1 hash engine. The caller gives it three things: the total message length in bytes, the last 0 to 3 message bytes that do not fill a whole 32-bit word, and the hash mode. The block then sends out the rest of the message as 32-bit words. First comes a marker word that carries the leftover bytes followed by the 0x80 terminator byte. Zero words follow. The last two words hold the 64-bit message length in bits. The stream always stops exactly at the end of a 64-byte block, so the hash engine can be told that the data is finished.

A one-cycle `start` pulse loads a request while the block is idle. `busy` stays high until the last word has been accepted. Words leave on a valid/ready stream. A word is transferred on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` keep their values. `done` pulses once the stream has finished. Bytes within a word use little-endian lanes: byte k sits in bits [8k+7:8k].

Top module: `mhp_pad_gen`

## Requirements
- R1: When `tail_len` is 1 to 3, the first word carries message bytes in lanes 0 to tail_len-1, taken from `tail_word` with the higher lanes masked off. It carries 0x80 in lane tail_len and zero in the lanes above it. The caller keeps `tail_len` equal to `msg_bytes` mod 4.
- R2: When `tail_len` is 0, the first word is exactly 32'h0000_0080.
- R3: Let w = (msg_bytes mod 64) div 4. When w is 13 or less, 16-w words are emitted. Every word between the first word and the two length words is zero, so the stream ends on a 64-byte boundary.
- R4: When w is 14 or 15, the length does not fit in the current block. In that case 32-w words are emitted, and the padding runs into the next block.
- R5: In MD5 mode (`mode`=0), let L = msg_bytes*8 as a 64-bit value. The last two words are L[31:0] and then L[63:32].
- R6: In SHA1 mode (`mode`=1), the last two words are L[63:32] byte-reversed and then L[31:0] byte-reversed. This equals the big-endian 64-bit length split into words.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values on the next cycle.
- R8: `done` is high for exactly one cycle. That cycle directly follows the edge on which the last length word was accepted. At that point `busy` and `out_valid` are already low.
- R9: A `start` pulse while `busy` is high is ignored, and the stream in progress continues unchanged.
- R10: After reset, `busy`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load a request when idle |
| mode | input | 1 | 0 = MD5, 1 = SHA1 |
| msg_bytes | input | CNT_W (61) | Total message length in bytes |
| tail_word | input | 32 | Leftover message bytes in low lanes |
| tail_len | input | 2 | Number of valid bytes in `tail_word` |
| busy | output | 1 | A request is being emitted |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 32 | Padding word |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The hardest case to reach from the ports is the block-rollover boundary. A marker word landing in word slot 13 must still fit the length in the current block, while one landing in slot 14 or 15 must push the padding into the next block. This has to hold for every number of leftover bytes. The bench therefore sweeps the byte count through more than two full blocks in both modes, which covers every marker position and every lane count. It also uses very large counts so the upper length word is not zero. Stalls on `out_ready` and a stray `start` during a stream are mixed into alternate requests, so the hold and ignore rules are tested while padding is in progress.

// File: rtl/mhp_pkg.sv
package mhp_pkg;
  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / 8;
  localparam int BLK_WORDS = 16;
  localparam int LEN_W     = 64;

  typedef enum logic {
    MODE_MD5  = 1'b0,
    MODE_SHA1 = 1'b1
  } hash_mode_e;

  typedef enum logic [1:0] {
    SEL_MARK = 2'd0,
    SEL_ZERO = 2'd1,
    SEL_LEN1 = 2'd2,
    SEL_LEN2 = 2'd3
  } word_sel_e;

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[8*i +: 8] = w[8*(LANES-1-i) +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/mhp_marker.sv
module mhp_marker
  import mhp_pkg::*;
#(
  parameter int LW = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] tail_word,
  input  logic [LW-1:0]     tail_len,
  output logic [WORD_W-1:0] marker_word
);
  // Each lane is data, terminator or zero depending on its position
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LW-1:0] LANE_ID = LW'(g);
    always_comb begin
      if (LANE_ID < tail_len)       marker_word[8*g +: 8] = tail_word[8*g +: 8];
      else if (LANE_ID == tail_len) marker_word[8*g +: 8] = 8'h80;
      else                          marker_word[8*g +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/mhp_length.sv
module mhp_length
  import mhp_pkg::*;
#(
  parameter int CNT_W = 61
) (
  input  logic [CNT_W-1:0]  msg_bytes,
  input  hash_mode_e        mode,
  output logic [WORD_W-1:0] len_first,
  output logic [WORD_W-1:0] len_second
);
  logic [LEN_W-1:0] bit_len;

  assign bit_len = LEN_W'(msg_bytes) << 3;

  always_comb begin
    if (mode == MODE_SHA1) begin
      len_first  = swap_bytes(bit_len[LEN_W-1:WORD_W]);
      len_second = swap_bytes(bit_len[WORD_W-1:0]);
    end else begin
      len_first  = bit_len[WORD_W-1:0];
      len_second = bit_len[LEN_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/mhp_span.sv
module mhp_span
  import mhp_pkg::*;
#(
  parameter int WP_W  = $clog2(BLK_WORDS),
  parameter int IDX_W = $clog2(2 * BLK_WORDS)
) (
  input  logic [WP_W-1:0]  word_pos,
  output logic [IDX_W-1:0] total_words
);
  // Last slot where the marker still leaves two words for the length
  localparam logic [WP_W-1:0] LAST_FIT = WP_W'(BLK_WORDS - 3);

  always_comb begin
    if (word_pos <= LAST_FIT) total_words = IDX_W'(BLK_WORDS) - IDX_W'(word_pos);
    else                      total_words = IDX_W'(2 * BLK_WORDS) - IDX_W'(word_pos);
  end
endmodule

// File: rtl/mhp_seq.sv
module mhp_seq
  import mhp_pkg::*;
#(
  parameter int IDX_W = $clog2(2 * BLK_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] total_in,
  input  logic             out_ready,
  output logic             busy,
  output word_sel_e        sel,
  output logic             done
);
  logic [IDX_W-1:0] idx_q, total_q;
  logic             busy_q, done_q, is_last, fire;

  assign is_last = (idx_q == total_q - IDX_W'(1));
  assign fire    = busy_q && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire && is_last;
      if (load) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        total_q <= total_in;
      end else if (fire) begin
        if (is_last) busy_q <= 1'b0;
        else         idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  always_comb begin
    if (idx_q == '0)                       sel = SEL_MARK;
    else if (is_last)                      sel = SEL_LEN2;
    else if (idx_q == total_q - IDX_W'(2)) sel = SEL_LEN1;
    else                                   sel = SEL_ZERO;
  end

  assign busy = busy_q;
  assign done = done_q;

  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q < total_q));
  a_r7_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !out_ready) |=> (busy_q && $stable(idx_q)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(fire && is_last) && !busy_q));
endmodule

// File: rtl/mhp_pad_gen.sv
module mhp_pad_gen
  import mhp_pkg::*;
#(
  parameter int CNT_W = 61
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  mode,
  input  logic [CNT_W-1:0]      msg_bytes,
  input  logic [WORD_W-1:0]     tail_word,
  input  logic [1:0]            tail_len,
  output logic                  busy,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WORD_W-1:0]     out_data,
  output logic                  done
);
  localparam int WP_W  = $clog2(BLK_WORDS);
  localparam int IDX_W = $clog2(2 * BLK_WORDS);

  logic [WORD_W-1:0] marker_c, len1_c, len2_c;
  logic [WORD_W-1:0] marker_q, len1_q, len2_q;
  logic [IDX_W-1:0]  total_c;
  logic              load;
  word_sel_e         sel;

  assign load = start && !busy;

  mhp_marker u_marker (
    .tail_word   (tail_word),
    .tail_len    (tail_len),
    .marker_word (marker_c)
  );

  mhp_length #(.CNT_W(CNT_W)) u_length (
    .msg_bytes  (msg_bytes),
    .mode       (hash_mode_e'(mode)),
    .len_first  (len1_c),
    .len_second (len2_c)
  );

  mhp_span u_span (
    .word_pos    (msg_bytes[WP_W+1:2]),
    .total_words (total_c)
  );

  mhp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .total_in  (total_c),
    .out_ready (out_ready),
    .busy      (busy),
    .sel       (sel),
    .done      (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      marker_q <= '0;
      len1_q   <= '0;
      len2_q   <= '0;
    end else if (load) begin
      marker_q <= marker_c;
      len1_q   <= len1_c;
      len2_q   <= len2_c;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MARK: out_data = marker_q;
      SEL_LEN1: out_data = len1_q;
      SEL_LEN2: out_data = len2_q;
      default:  out_data = '0;
    endcase
  end

  assign out_valid = busy;

  a_r1_tail_contract: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (tail_len == msg_bytes[1:0]));
  a_r4_block_end: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (((IDX_W'(msg_bytes[WP_W+1:2]) + total_c) % IDX_W'(BLK_WORDS)) == '0));
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !out_ready) |=> $stable(out_data));
endmodule

// File: tb/tb_mhp_pad_gen.sv
module tb_mhp_pad_gen;
  localparam int CNT_W = 61;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             mode = 1'b0;
  logic [CNT_W-1:0] msg_bytes = '0;
  logic [31:0]      tail_word = '0;
  logic [1:0]       tail_len = '0;
  logic             busy, out_valid, done;
  logic             out_ready = 1'b0;
  logic [31:0]      out_data;

  int errs = 0;
  int checks = 0;
  logic [31:0] exp_w [0:31];

  always #4 clk = ~clk;

  mhp_pad_gen #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .msg_bytes(msg_bytes), .tail_word(tail_word), .tail_len(tail_len),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic run(input logic [63:0] cnt, input logic md, input logic [31:0] tw, input bit bp);
    int tl, wpos, n, k, step;
    logic [63:0] blen;
    logic [31:0] mask;
    string tag;
    bit stalled;
    tl   = int'(cnt % 4);
    wpos = int'((cnt % 64) / 4);
    n    = (wpos <= 13) ? 16 - wpos : 32 - wpos;
    blen = cnt << 3;
    mask = (tl == 0) ? 32'h0 : ((32'h1 << (8 * tl)) - 1);
    for (int i = 0; i < 32; i++) exp_w[i] = 32'h0;
    exp_w[0] = (tw & mask) | (32'h80 << (8 * tl));
    exp_w[n-2] = md ? bsw(blen[63:32]) : blen[31:0];
    exp_w[n-1] = md ? bsw(blen[31:0])  : blen[63:32];

    @(negedge clk);
    start = 1'b1; mode = md; msg_bytes = cnt[CNT_W-1:0];
    tail_word = tw; tail_len = 2'(tl); out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    k = 0; step = 0; stalled = 1'b0;
    while (k < n && step < 200) begin
      if (bp && step == 2) begin
        start = 1'b1; mode = ~md; msg_bytes = cnt[CNT_W-1:0] + 61'd5;
        tail_len = 2'((cnt + 5) % 4); tail_word = ~tw;
      end
      if (k == 0) tag = (tl != 0) ? "R1" : "R2";
      else if (k >= n - 2) tag = md ? "R6" : "R5";
      else tag = "R3";
      if (stalled) tag = "R7";
      if (bp && step == 3) tag = "R9";
      check(out_valid === 1'b1, "R7 valid", 64'(out_valid), 64'd1);
      check(out_data === exp_w[k], tag, 64'(out_data), 64'(exp_w[k]));
      out_ready = bp ? ((step % 3) != 1) : 1'b1;
      stalled = !out_ready;
      if (out_ready) k++;
      @(negedge clk);
      start = 1'b0;
      step++;
    end
    out_ready = 1'b0;
    // last word was accepted on the edge just passed
    check(done === 1'b1, "R8 done", 64'(done), 64'd1);
    check(out_valid === 1'b0 && busy === 1'b0, (wpos >= 14) ? "R4 count" : "R3 count",
          64'({busy, out_valid}), 64'd0);
    @(negedge clk);
    check(done === 1'b0, "R8 pulse", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R10 reset",
          64'({busy, out_valid, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R10 idle",
          64'({busy, out_valid, done}), 64'd0);
    for (int c = 0; c < 144; c++) begin
      for (int m = 0; m < 2; m++) begin
        run(64'(c), m[0], 32'hA5C3_5A3C ^ (32'(c) * 32'h0101_0101), c[0]);
      end
    end
    run(64'h0123_4567_89AB_CDEF, 1'b0, 32'hDEAD_BEEF, 1'b0);
    run(64'h0123_4567_89AB_CDEF, 1'b1, 32'hDEAD_BEEF, 1'b1);
    run(64'h1FFF_FFFF_FFFF_FFF8, 1'b1, 32'h1234_5678, 1'b0);
    run(64'h0000_0001_0000_003B, 1'b0, 32'hFFFF_FFFF, 1'b1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule